// File: doc/BRIEF.md
# Instruction Cache Tag Store with Memory-Mapped Access

This block holds the tag and valid bit of every line in a 256-entry direct-mapped instruction cache. It has two ports. The lookup port takes a fetch address and a physical tag and reports hit or miss. A line is selected by the fetch address bits above the 32-byte line offset. A mode input can swap the top index bit for a high address bit, so that the cache is split into two halves chosen by that bit.

The second port maps the tag store into a fixed address window. Software uses it with privileged 32-bit data accesses. Through it, software can read an entry, overwrite an entry, or perform an associative write. An associative write only touches an entry whose stored tag equals the tag it supplies. A separate input clears every valid bit in one cycle.

Both ports are pipelined. A request is sampled on one clock edge and its response is registered on the next edge. Any request sampled on an edge sees every update that commits on that same edge. A request that carries a tag takes the tag from data bits [28:10].

Top module: `itag_store`

## Requirements
- R1: With `idx_mode` low, a lookup selects entry `lk_ea[12:5]`.
- R2: With `idx_mode` high, a lookup selects entry `{lk_ea[25], lk_ea[11:5]}`, so bit 12 plays no part in the selection.
- R3: A lookup sampled on edge N raises `lk_vld` after edge N+1. `lk_hit` rises with it only when the selected entry is valid and its stored tag equals `lk_ptag`.
- R4: A memory-mapped request is taken only when `mm_addr[31:24]` is 0xF0. Any other address gets no `mm_ack` and changes no entry.
- R5: A memory-mapped access selects entry `mm_addr[12:5]` in every value of `idx_mode`.
- R6: A write with `mm_addr[3]`=0 stores `mm_wdata[28:10]` as the tag and `mm_wdata[0]` as the valid bit. Bits [31:29] of the write data are ignored.
- R7: A write with `mm_addr[3]`=1 is associative. It sets the valid bit to `mm_wdata[0]` only when the entry is valid and its tag equals `mm_wdata[28:10]`; otherwise the entry is left unchanged.
- R8: A read returns the tag in bits [28:10] and the valid bit in bit 0, with all other bits zero. `mm_ack` and `mm_rdata` appear after the edge following the sampling edge.
- R9: An in-window request is rejected if `mm_priv` is 0, if `mm_word` is 0, or if `mm_addr[1:0]` is nonzero. A rejected request is acknowledged with `mm_err`=1 and `mm_rdata`=0, and it changes nothing.
- R10: `inv_all` clears every valid bit at the edge that samples it. This takes priority over the valid bit of a write committing on that edge, although that write's tag is still stored.
- R11: A lookup or memory-mapped request sampled on the same edge as a committing write sees the written contents.
- R12: After a synchronous reset, all outputs are low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_mode | input | 1 | Selects the split lookup index |
| inv_all | input | 1 | Clears every valid bit |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Fetch effective address |
| lk_ptag | input | 19 | Physical tag to compare |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| mm_req | input | 1 | Memory-mapped request |
| mm_wr | input | 1 | 1 = write, 0 = read |
| mm_priv | input | 1 | Request is privileged |
| mm_word | input | 1 | Request is a 32-bit access |
| mm_addr | input | 32 | Request address |
| mm_wdata | input | 32 | Write data |
| mm_ack | output | 1 | Response for an in-window request |
| mm_err | output | 1 | Request was rejected |
| mm_rdata | output | 32 | Read data |

## Verification
Two pairs of functions can meet in one cycle. In the first, a memory-mapped write commits on the same edge that samples a lookup or a second memory-mapped access to the same entry. In the second, `inv_all` arrives on the edge where a write commits. Directed sequences place the second request exactly one cycle after the write, and place `inv_all` exactly on the commit edge. A long random phase confines addresses to sixteen entries and four tag values, so that these collisions and associative matches happen often. A behavioural model in the bench applies commits before sampling. It is compared with every output on every cycle, which judges both the forwarding and the priority of the invalidate.

// File: rtl/itag_pkg.sv
package itag_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    MM_READ  = 2'd0,
    MM_WRITE = 2'd1,
    MM_ASSOC = 2'd2
  } mm_kind_e;
endpackage

// File: rtl/itag_index.sv
module itag_index import itag_pkg::*; #(
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned LINE_LSB = 5,
  parameter int unsigned ALT_BIT  = 25
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic              idx_mode,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] plain_idx;
  logic [IDX_W-1:0] split_idx;
  logic             unused_ea;

  assign plain_idx = ea[LINE_LSB +: IDX_W];
  assign split_idx = {ea[ALT_BIT], ea[LINE_LSB +: IDX_W-1]};
  assign idx       = idx_mode ? split_idx : plain_idx;
  assign unused_ea = ^ea;
endmodule

// File: rtl/itag_mm_decode.sv
module itag_mm_decode import itag_pkg::*; #(
  parameter int unsigned     IDX_W     = 8,
  parameter int unsigned     TAG_W     = 19,
  parameter int unsigned     LINE_LSB  = 5,
  parameter int unsigned     TAG_LSB   = 10,
  parameter int unsigned     ASSOC_BIT = 3,
  parameter int unsigned     WIN_LSB   = 24,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
  input  logic              req,
  input  logic              wr,
  input  logic              priv,
  input  logic              word_acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit_win,
  output logic              ok,
  output mm_kind_e          kind,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  wtag,
  output logic              wval
);
  logic unused_bits;

  assign hit_win = req && (addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);
  assign ok      = priv && word_acc && (addr[1:0] == 2'b00);
  assign idx     = addr[LINE_LSB +: IDX_W];
  assign wtag    = wdata[TAG_LSB +: TAG_W];
  assign wval    = wdata[0];

  always_comb begin
    if (!wr)                 kind = MM_READ;
    else if (addr[ASSOC_BIT]) kind = MM_ASSOC;
    else                     kind = MM_WRITE;
  end

  assign unused_bits = ^{addr, wdata};
endmodule

// File: rtl/itag_tag_ram.sv
module itag_tag_ram #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned TAG_W = 19,
  parameter int unsigned NRD   = 2
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [IDX_W-1:0]       waddr,
  input  logic [TAG_W-1:0]       wdata,
  input  logic [NRD*IDX_W-1:0]   raddr,
  output logic [NRD*TAG_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [TAG_W-1:0] q;
    logic             byp;
    logic [TAG_W-1:0] byp_d;
    always_ff @(posedge clk) begin
      q     <= mem[raddr[p*IDX_W +: IDX_W]];
      byp   <= we && (waddr == raddr[p*IDX_W +: IDX_W]);
      byp_d <= wdata;
    end
    assign rdata[p*TAG_W +: TAG_W] = byp ? byp_d : q;
  end
endmodule

// File: rtl/itag_valid_vec.sv
module itag_valid_vec #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned NRD   = 2,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inv_all,
  input  logic                 we,
  input  logic [IDX_W-1:0]     waddr,
  input  logic                 wval,
  input  logic [NRD*IDX_W-1:0] raddr,
  output logic [NRD-1:0]       rval,
  output logic [ENTRIES-1:0]   vld_q
);
  logic [ENTRIES-1:0] vld_nxt;

  always_comb begin
    vld_nxt = vld_q;
    if (we) vld_nxt[waddr] = wval;
    if (inv_all) vld_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= vld_nxt;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rval[p] <= 1'b0;
      else     rval[p] <= vld_nxt[raddr[p*IDX_W +: IDX_W]];
    end
  end
endmodule

// File: rtl/itag_store.sv
module itag_store import itag_pkg::*; #(
  parameter int unsigned       IDX_W     = 8,
  parameter int unsigned       TAG_W     = 19,
  parameter int unsigned       LINE_LSB  = 5,
  parameter int unsigned       ALT_BIT   = 25,
  parameter int unsigned       TAG_LSB   = 10,
  parameter int unsigned       ASSOC_BIT = 3,
  parameter int unsigned       WIN_LSB   = 24,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_mode,
  input  logic              inv_all,
  input  logic              lk_req,
  input  logic [31:0]       lk_ea,
  input  logic [TAG_W-1:0]  lk_ptag,
  output logic              lk_vld,
  output logic              lk_hit,
  input  logic              mm_req,
  input  logic              mm_wr,
  input  logic              mm_priv,
  input  logic              mm_word,
  input  logic [31:0]       mm_addr,
  input  logic [31:0]       mm_wdata,
  output logic              mm_ack,
  output logic              mm_err,
  output logic [31:0]       mm_rdata
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned NRD     = 2;

  // front-end decode
  logic [IDX_W-1:0] lk_idx;
  logic             dec_win, dec_ok, dec_wval;
  mm_kind_e         dec_kind;
  logic [IDX_W-1:0] dec_idx;
  logic [TAG_W-1:0] dec_wtag;

  itag_index #(.IDX_W(IDX_W), .LINE_LSB(LINE_LSB), .ALT_BIT(ALT_BIT)) u_index (
    .ea(lk_ea), .idx_mode(idx_mode), .idx(lk_idx)
  );

  itag_mm_decode #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_LSB(LINE_LSB), .TAG_LSB(TAG_LSB),
    .ASSOC_BIT(ASSOC_BIT), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .req(mm_req), .wr(mm_wr), .priv(mm_priv), .word_acc(mm_word),
    .addr(mm_addr), .wdata(mm_wdata),
    .hit_win(dec_win), .ok(dec_ok), .kind(dec_kind), .idx(dec_idx),
    .wtag(dec_wtag), .wval(dec_wval)
  );

  // stage 1: sampled requests
  logic             lk_s1_act;
  logic [TAG_W-1:0] lk_s1_ptag;
  logic             mm_s1_act, mm_s1_ok, mm_s1_wv;
  mm_kind_e         mm_s1_kind;
  logic [IDX_W-1:0] mm_s1_idx;
  logic [TAG_W-1:0] mm_s1_wtag;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_s1_act  <= 1'b0;
      lk_s1_ptag <= '0;
      mm_s1_act  <= 1'b0;
      mm_s1_ok   <= 1'b0;
      mm_s1_wv   <= 1'b0;
      mm_s1_kind <= MM_READ;
      mm_s1_idx  <= '0;
      mm_s1_wtag <= '0;
    end else begin
      lk_s1_act  <= lk_req;
      lk_s1_ptag <= lk_ptag;
      mm_s1_act  <= dec_win;
      mm_s1_ok   <= dec_ok;
      mm_s1_wv   <= dec_wval;
      mm_s1_kind <= dec_kind;
      mm_s1_idx  <= dec_idx;
      mm_s1_wtag <= dec_wtag;
    end
  end

  // storage: port 0 serves lookups, port 1 the memory-mapped path
  logic [NRD*IDX_W-1:0] rd_addr;
  logic [NRD*TAG_W-1:0] rd_tags;
  logic [NRD-1:0]       rd_vals;
  logic [ENTRIES-1:0]   vld_all;
  logic                 wr_en;
  logic [TAG_W-1:0]     lk_tag, mm_tag;

  assign rd_addr = {dec_idx, lk_idx};
  assign lk_tag  = rd_tags[0 +: TAG_W];
  assign mm_tag  = rd_tags[TAG_W +: TAG_W];

  // commit: direct writes always, associative writes on a valid tag match
  always_comb begin
    wr_en = 1'b0;
    if (mm_s1_act && mm_s1_ok) begin
      unique case (mm_s1_kind)
        MM_WRITE: wr_en = 1'b1;
        MM_ASSOC: wr_en = rd_vals[1] && (mm_tag == mm_s1_wtag);
        default:  wr_en = 1'b0;
      endcase
    end
  end

  itag_tag_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NRD(NRD)) u_tags (
    .clk(clk), .we(wr_en), .waddr(mm_s1_idx), .wdata(mm_s1_wtag),
    .raddr(rd_addr), .rdata(rd_tags)
  );

  itag_valid_vec #(.IDX_W(IDX_W), .NRD(NRD)) u_vld (
    .clk(clk), .rst(rst), .inv_all(inv_all), .we(wr_en), .waddr(mm_s1_idx),
    .wval(mm_s1_wv), .raddr(rd_addr), .rval(rd_vals), .vld_q(vld_all)
  );

  // stage 2: registered responses
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    rd_word[TAG_LSB +: TAG_W] = mm_tag;
    rd_word[0] = rd_vals[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld   <= 1'b0;
      lk_hit   <= 1'b0;
      mm_ack   <= 1'b0;
      mm_err   <= 1'b0;
      mm_rdata <= '0;
    end else begin
      lk_vld   <= lk_s1_act;
      lk_hit   <= lk_s1_act && rd_vals[0] && (lk_tag == lk_s1_ptag);
      mm_ack   <= mm_s1_act;
      mm_err   <= mm_s1_act && !mm_s1_ok;
      mm_rdata <= (mm_s1_act && mm_s1_ok && mm_s1_kind == MM_READ) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/itag_store_chk.sv
module itag_store_chk import itag_pkg::*; #(
  parameter int unsigned       ENTRIES = 256,
  parameter int unsigned       TAG_W   = 19,
  parameter int unsigned       TAG_LSB = 10,
  parameter int unsigned       WIN_LSB = 24,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
  input logic               clk,
  input logic               rst,
  input logic               inv_all,
  input logic               lk_req,
  input logic               lk_vld,
  input logic               lk_hit,
  input logic               mm_req,
  input logic [31:0]        mm_addr,
  input logic               mm_ack,
  input logic               mm_err,
  input logic [31:0]        mm_rdata,
  input logic [ENTRIES-1:0] vld_all
);
  logic in_win;
  assign in_win = mm_req && (mm_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB]);

  // R12
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_vld && !mm_ack && !mm_err && vld_all == '0));

  // R3
  lk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (lk_vld == $past(lk_req, 2)));

  // R3
  hit_has_vld_chk: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_vld);

  // R4
  mm_window_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (mm_ack == $past(in_win, 2)));

  // R9
  reject_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mm_err |-> (mm_ack && mm_rdata == '0));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mm_ack |-> (mm_rdata[31:TAG_LSB+TAG_W] == '0 && mm_rdata[TAG_LSB-1:1] == '0));

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inv_all)) |-> (vld_all == '0));
endmodule

bind itag_store itag_store_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB),
  .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst(rst), .inv_all(inv_all), .lk_req(lk_req), .lk_vld(lk_vld),
  .lk_hit(lk_hit), .mm_req(mm_req), .mm_addr(mm_addr), .mm_ack(mm_ack),
  .mm_err(mm_err), .mm_rdata(mm_rdata), .vld_all(vld_all)
);

// File: tb/itag_store_bench.sv
`timescale 1ns/1ps
module itag_store_bench;
  logic        clk = 1'b0, rst = 1'b1, idx_mode = 1'b0, inv_all = 1'b0;
  logic        lk_req = 1'b0, mm_req = 1'b0, mm_wr = 1'b0, mm_priv = 1'b1, mm_word = 1'b1;
  logic [31:0] lk_ea = '0, mm_addr = '0, mm_wdata = '0;
  logic [18:0] lk_ptag = '0;
  logic        lk_vld, lk_hit, mm_ack, mm_err;
  logic [31:0] mm_rdata;

  always #10 clk = ~clk;

  itag_store u_itag_store (
    .clk(clk), .rst(rst), .idx_mode(idx_mode), .inv_all(inv_all),
    .lk_req(lk_req), .lk_ea(lk_ea), .lk_ptag(lk_ptag), .lk_vld(lk_vld), .lk_hit(lk_hit),
    .mm_req(mm_req), .mm_wr(mm_wr), .mm_priv(mm_priv), .mm_word(mm_word),
    .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_ack(mm_ack), .mm_err(mm_err),
    .mm_rdata(mm_rdata)
  );

  int    vectors = 0, miscompares = 0;
  string cur_req = "R12";
  bit    cmp_on = 1'b0, done = 1'b0;

  // behavioural reference: commits first, then sampling
  logic [18:0] m_tag [256];
  bit          m_v   [256];
  bit          m_kn  [256];
  bit          p_lk, p_lsv, p_mm, p_ok, p_wr, p_as, p_wv, p_sv, p_kn;
  logic [18:0] p_lst, p_lpt, p_wt, p_st;
  logic [7:0]  p_idx, m_li;
  bit          e_lv, e_lh, e_ack, e_err;
  logic [31:0] e_rd, e_mask;

  initial begin
    for (int i = 0; i < 256; i++) begin m_tag[i] = '0; m_v[i] = 0; m_kn[i] = 0; end
    p_lk = 0; p_mm = 0; e_lv = 0; e_lh = 0; e_ack = 0; e_err = 0; e_rd = '0; e_mask = '1;
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) m_v[i] = 0;
      p_lk = 0; p_mm = 0; e_lv = 0; e_lh = 0; e_ack = 0; e_err = 0; e_rd = '0; e_mask = '1;
    end else begin
      e_lv = p_lk;
      e_lh = p_lk && p_lsv && (p_lst == p_lpt);
      e_ack = p_mm;
      e_err = p_mm && !p_ok;
      e_rd = '0; e_mask = '1;
      if (p_mm && p_ok && !p_wr) begin
        e_rd[28:10] = p_st; e_rd[0] = p_sv;
        if (!p_kn) e_mask[28:10] = '0;
      end
      if (p_mm && p_ok && p_wr) begin
        if (!p_as) begin m_tag[p_idx] = p_wt; m_kn[p_idx] = 1; m_v[p_idx] = p_wv; end
        else if (p_sv && p_st == p_wt) m_v[p_idx] = p_wv;
      end
      if (inv_all) for (int i = 0; i < 256; i++) m_v[i] = 0;
      p_lk  = lk_req;
      m_li  = idx_mode ? {lk_ea[25], lk_ea[11:5]} : lk_ea[12:5];
      p_lsv = m_v[m_li]; p_lst = m_tag[m_li]; p_lpt = lk_ptag;
      p_mm  = mm_req && (mm_addr[31:24] == 8'hF0);
      p_ok  = mm_priv && mm_word && (mm_addr[1:0] == 2'b00);
      p_wr  = mm_wr; p_as = mm_addr[3]; p_idx = mm_addr[12:5];
      p_wt  = mm_wdata[28:10]; p_wv = mm_wdata[0];
      p_sv  = m_v[p_idx]; p_st = m_tag[p_idx]; p_kn = m_kn[p_idx];
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (lk_vld !== e_lv || lk_hit !== e_lh || mm_ack !== e_ack || mm_err !== e_err ||
          (mm_rdata & e_mask) !== (e_rd & e_mask)) begin
        miscompares++;
        $display("FAIL %s cycle: vld/hit=%b%b exp %b%b ack/err=%b%b exp %b%b rdata=%h exp %h",
                 cur_req, lk_vld, lk_hit, e_lv, e_lh, mm_ack, mm_err, e_ack, e_err,
                 mm_rdata & e_mask, e_rd & e_mask);
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mma(logic [7:0] idx, bit assoc);
    return 32'hF000_0000 | (32'(idx) << 5) | (32'(assoc) << 3);
  endfunction

  function automatic logic [31:0] wd(logic [18:0] tag, bit v, logic [2:0] top);
    return {top, tag, 9'b0, v};
  endfunction

  // drive one request, return the registered response
  task automatic mm_do(bit wr, logic [31:0] a, logic [31:0] d, bit pv, bit wd32,
                       output logic [31:0] rd, output bit ack, output bit err);
    mm_req = 1; mm_wr = wr; mm_addr = a; mm_wdata = d; mm_priv = pv; mm_word = wd32;
    @(negedge clk);
    mm_req = 0; mm_priv = 1; mm_word = 1;
    @(negedge clk);
    rd = mm_rdata; ack = mm_ack; err = mm_err;
  endtask

  task automatic lk_do(logic [31:0] ea, logic [18:0] pt, output bit v, output bit h);
    lk_req = 1; lk_ea = ea; lk_ptag = pt;
    @(negedge clk);
    lk_req = 0;
    @(negedge clk);
    v = lk_vld; h = lk_hit;
  endtask

  initial begin
    logic [31:0] rd;
    bit ack, err, v, h;

    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R12
    chk(!lk_vld && !lk_hit && !mm_ack && !mm_err, "R12", "outputs in reset",
        {lk_vld, lk_hit, mm_ack, mm_err}, 0);
    rst = 0;
    @(negedge clk);
    mm_do(0, mma(8'd5, 0), 0, 1, 1, rd, ack, err);
    chk(ack && !err && rd[0] == 0, "R12", "entry 5 invalid after reset", rd & 1, 0);

    // R6 R8: direct write ignores data bits 31:29, read layout
    cur_req = "R6";
    mm_do(1, mma(8'd3, 0), wd(19'h5A5A5, 1, 3'b111), 1, 1, rd, ack, err);
    chk(ack && !err && rd == 0, "R6", "write response", rd, 0);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h5A5A5, 1, 3'b000), "R8", "read entry 3", rd, wd(19'h5A5A5, 1, 3'b000));

    // R1 R3: plain index lookup
    cur_req = "R1";
    lk_do((32'd3 << 5) | 32'h11, 19'h5A5A5, v, h);
    chk(v && h, "R1", "hit on entry 3", {v, h}, 2'b11);
    lk_do(32'd3 << 5, 19'h5A5A4, v, h);
    chk(v && !h, "R3", "tag mismatch misses", {v, h}, 2'b10);
    lk_do(32'd4 << 5, 19'h5A5A5, v, h);
    chk(v && !h, "R3", "invalid entry misses", {v, h}, 2'b10);

    // R2 R5: split index and window selection
    cur_req = "R2";
    mm_do(1, mma(8'h83, 0), wd(19'h11111, 1, 3'b000), 1, 1, rd, ack, err);
    lk_do((32'd3 << 5) | (32'd1 << 12), 19'h11111, v, h);
    chk(v && h, "R1", "bit 12 selects entry 0x83", {v, h}, 2'b11);
    idx_mode = 1;
    lk_do((32'd1 << 25) | (32'd3 << 5), 19'h11111, v, h);
    chk(v && h, "R2", "bit 25 selects entry 0x83", {v, h}, 2'b11);
    lk_do((32'd1 << 12) | (32'd3 << 5), 19'h5A5A5, v, h);
    chk(v && h, "R2", "bit 12 ignored in split mode", {v, h}, 2'b11);
    mm_do(0, mma(8'h83, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h11111, 1, 3'b000), "R5", "window read unaffected by mode", rd,
        wd(19'h11111, 1, 3'b000));
    idx_mode = 0;

    // R7: associative writes
    cur_req = "R7";
    mm_do(1, mma(8'd3, 1), wd(19'h12345, 0, 3'b000), 1, 1, rd, ack, err);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h5A5A5, 1, 3'b000), "R7", "mismatch leaves entry", rd, wd(19'h5A5A5, 1, 3'b000));
    mm_do(1, mma(8'd3, 1), wd(19'h5A5A5, 0, 3'b101), 1, 1, rd, ack, err);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h5A5A5, 0, 3'b000), "R7", "match clears valid", rd, wd(19'h5A5A5, 0, 3'b000));
    mm_do(1, mma(8'd3, 1), wd(19'h5A5A5, 1, 3'b000), 1, 1, rd, ack, err);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h5A5A5, 0, 3'b000), "R7", "invalid entry not revived", rd, wd(19'h5A5A5, 0, 3'b000));

    // R4: outside the window
    cur_req = "R4";
    mm_do(1, 32'hF100_0000 | (32'd3 << 5), wd(19'h5A5A5, 1, 3'b000), 1, 1, rd, ack, err);
    chk(!ack, "R4", "no ack outside window", {31'b0, ack}, 0);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd[0] == 0, "R4", "entry untouched", rd & 1, 0);

    // R9: rejected requests
    cur_req = "R9";
    mm_do(1, mma(8'd3, 0), wd(19'h5A5A5, 1, 3'b000), 0, 1, rd, ack, err);
    chk(ack && err && rd == 0, "R9", "unprivileged", {ack, err}, 2'b11);
    mm_do(1, mma(8'd3, 0), wd(19'h5A5A5, 1, 3'b000), 1, 0, rd, ack, err);
    chk(ack && err && rd == 0, "R9", "short access", {ack, err}, 2'b11);
    mm_do(0, mma(8'd3, 0) | 32'h2, 0, 1, 1, rd, ack, err);
    chk(ack && err && rd == 0, "R9", "misaligned read", rd, 0);
    mm_do(0, mma(8'd3, 0), 0, 1, 1, rd, ack, err);
    chk(rd[0] == 0, "R9", "entry unchanged", rd & 1, 0);

    // R10: invalidate all, and against a committing write
    cur_req = "R10";
    mm_do(1, mma(8'd10, 0), wd(19'h00A0A, 1, 3'b000), 1, 1, rd, ack, err);
    inv_all = 1; @(negedge clk); inv_all = 0;
    mm_do(0, mma(8'd10, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h00A0A, 0, 3'b000), "R10", "valid cleared", rd, wd(19'h00A0A, 0, 3'b000));
    mm_req = 1; mm_wr = 1; mm_addr = mma(8'd12, 0); mm_wdata = wd(19'h0ABCD, 1, 3'b000);
    @(negedge clk); mm_req = 0; inv_all = 1;
    @(negedge clk); inv_all = 0;
    mm_do(0, mma(8'd12, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h0ABCD, 0, 3'b000), "R10", "invalidate wins, tag kept", rd, wd(19'h0ABCD, 0, 3'b000));

    // R11: same-edge visibility
    cur_req = "R11";
    mm_req = 1; mm_wr = 1; mm_addr = mma(8'd20, 0); mm_wdata = wd(19'h33333, 1, 3'b000);
    @(negedge clk); mm_req = 0; lk_req = 1; lk_ea = 32'd20 << 5; lk_ptag = 19'h33333;
    @(negedge clk); lk_req = 0;
    @(negedge clk);
    chk(lk_vld && lk_hit, "R11", "lookup sees fresh write", {lk_vld, lk_hit}, 2'b11);
    mm_req = 1; mm_wr = 1; mm_addr = mma(8'd21, 0); mm_wdata = wd(19'h44444, 1, 3'b000);
    @(negedge clk); mm_addr = mma(8'd21, 1); mm_wdata = wd(19'h44444, 0, 3'b000);
    @(negedge clk); mm_req = 0;
    @(negedge clk);
    mm_do(0, mma(8'd21, 0), 0, 1, 1, rd, ack, err);
    chk(rd == wd(19'h44444, 0, 3'b000), "R11", "associative sees fresh write", rd,
        wd(19'h44444, 0, 3'b000));

    // random collisions over sixteen entries, judged by the model each cycle
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ri;
      ri = {1'($urandom), 4'b0, 3'($urandom)};
      lk_req   = 1'($urandom);
      lk_ea    = (32'($urandom % 2) << 25) | (32'($urandom % 2) << 12) | (32'($urandom % 8) << 5);
      lk_ptag  = 19'($urandom % 4);
      mm_req   = 1'($urandom);
      mm_wr    = ($urandom % 3) != 0;
      mm_addr  = (($urandom % 8 == 0) ? 32'hF200_0000 : 32'hF000_0000) | (32'(ri) << 5) |
                 (32'($urandom % 2) << 3) | (($urandom % 12 == 0) ? 32'h2 : 32'h0);
      mm_wdata = wd(19'($urandom % 4), 1'($urandom), 3'($urandom));
      mm_priv  = ($urandom % 16) != 0;
      mm_word  = ($urandom % 16) != 0;
      inv_all  = ($urandom % 40) == 0;
      if ($urandom % 100 == 0) idx_mode = ~idx_mode;
      @(negedge clk);
    end
    lk_req = 0; mm_req = 0; inv_all = 0; mm_priv = 1; mm_word = 1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule